// File: doc/BRIEF.md
# Error Capture and Logging Unit

This unit sits beside the packet receive logic of a chip's local register block and records the protocol errors that the receive logic finds in incoming request and reply packets. Each kind of error arrives as its own one-cycle strobe. The unit keeps a sticky status vector with one bit per error kind and holds its interrupt request high while any of those bits is set.

For the first error that finds the capture registers empty, the unit also records that packet's header fields, its address and one data flit. Later errors set an overrun flag and leave the first record in place. The global clock-dropout error is exempt from capture: it only sets its status bit.

Software reaches the unit through a small register port with a combinational read path. Through that port it can read the status vector and the captured record, clear chosen status bits in one write, and set status bits and load the capture registers directly, so that it can stage a fake error and exercise its own error handler.

Top module: `err_log_unit`

## Requirements
- R1: A strobe on `err_strobe[i]` sets status bit i at the next clock edge, and the bit then stays set. The bit order from bit 0 is: request bad command, reply bad command, request short, reply short, request long, reply long, request bad data, reply bad data, request bad address, request bad invalidate, global clock drop (bit 10).
- R2: Reading any register changes no state. The status vector keeps its contents while `rst_n` is low.
- R3: `irq` is 1 exactly when at least one status bit is set.
- R4: A write to address 0 (status) sets every status bit whose `reg_wdata` bit is 1. Bits written as 0 keep their value.
- R5: A write to address 1 (clear mask) clears every status bit whose `reg_wdata` bit is 1 and leaves all other bits unchanged. If a strobe for a bit arrives in the same cycle as a clear of that bit, the bit ends up set.
- R6: Suppose at least one strobe other than clock drop arrives while VALID is 0. At the next edge the unit loads command, supplemental, source and address from the packet inputs, sets VALID, clears OVERRUN, and loads the type field with the index of the lowest such strobe (for example, 5 for reply long).
- R7: A strobe other than clock drop that arrives while VALID is 1 sets OVERRUN and leaves type, command, supplemental, source, address and data unchanged.
- R8: A clock-drop strobe on its own changes neither type, VALID, OVERRUN nor any captured field.
- R9: Header word 1 (address 2) holds command in bits 6:0, supplemental in 18:8, source in 30:20, type in 35:32, OVERRUN in bit 40 and VALID in bit 44. Header word 2 (address 3) holds the 38-bit address in bits 37:0.
- R10: On a capture, the data register (address 4) loads `pkt_flit3` when `pkt_is_vector` is 1 and `pkt_flit2` otherwise.
- R11: A write to address 2 loads all header word 1 fields from `reg_wdata` in the same layout, so writing 0 clears VALID. This write is discarded in a cycle that has a strobe other than clock drop. Writes to addresses 3 and 4 load the address and data registers, except in a cycle that captures.
- R12: Reserved bits read as 0. Address 1 and addresses 5 to 7 read as 0. Reset clears all capture registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (capture registers only) |
| err_strobe | input | NUM_ERR (11) | One-cycle error strobes, one per error kind |
| pkt_cmd | input | CMD_W (7) | Command field of the offending packet header |
| pkt_suppl | input | SUP_W (11) | Supplemental field of the header |
| pkt_src | input | SRC_W (11) | Source field of the header |
| pkt_addr | input | ADDR_W (38) | Address field of the header |
| pkt_is_vector | input | 1 | Packet is a vector PIO packet |
| pkt_flit2 | input | 64 | Second flit of the packet |
| pkt_flit3 | input | 64 | Third flit of the packet |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 status, 1 clear, 2 hdr1, 3 hdr2, 4 data) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt request while any status bit is set |

## Verification
The bench targets the following corner cases. Each is listed with what a faulty design would show on the ports.

- **Error collision.** A second error arrives while a record is held. A design that recaptures would replace the first header and type; one that misses the overrun would keep OVERRUN at 0.
- **Clock-drop strobe.** The bench sends it both with VALID at 0 and with VALID at 1. A design that treats it like the other errors would set VALID or OVERRUN, or load a type of 10.
- **Set against clear.** A clear mask and a strobe for the same bit land in one cycle. If the clear won, the bit and possibly `irq` would drop.
- **Reset persistence and capture priority.** After a reset the status bits must still read back. A software header write that meets a real error must lose, or the captured record would be corrupted.

// File: rtl/err_log_pkg.sv
package err_log_pkg;
   localparam int unsigned WORD_W      = 64;
   localparam int unsigned RADDR_W     = 3;
   // header word 1 field positions (software decodes these)
   localparam int unsigned H1_CMD_LSB  = 0;
   localparam int unsigned H1_SUP_LSB  = 8;
   localparam int unsigned H1_SRC_LSB  = 20;
   localparam int unsigned H1_TYPE_LSB = 32;
   localparam int unsigned H1_OVR_BIT  = 40;
   localparam int unsigned H1_VLD_BIT  = 44;

   typedef enum logic [RADDR_W-1:0] {
      RSEL_STATUS = 3'd0,
      RSEL_CLEAR  = 3'd1,
      RSEL_HDR1   = 3'd2,
      RSEL_HDR2   = 3'd3,
      RSEL_DATA   = 3'd4
   } reg_sel_e;
endpackage

// File: rtl/err_status_vec.sv
module err_status_vec #(
   parameter int unsigned NUM_ERR = 11
) (
   input  logic               clk,
   input  logic [NUM_ERR-1:0] hw_set,
   input  logic [NUM_ERR-1:0] sw_set,
   input  logic [NUM_ERR-1:0] sw_clr,
   output logic [NUM_ERR-1:0] status,
   output logic               any_set
);
   // one flop per error kind; no reset so that logged errors outlive it
   for (genvar b = 0; b < NUM_ERR; b++) begin : g_bit
      logic bit_q = 1'b0;
      always_ff @(posedge clk) begin
         bit_q <= hw_set[b] | sw_set[b] | (bit_q & ~sw_clr[b]);
      end
      assign status[b] = bit_q;
   end

   assign any_set = |status;
endmodule

// File: rtl/err_capture.sv
module err_capture
   import err_log_pkg::*;
#(
   parameter int unsigned NUM_ERR     = 11,
   parameter int unsigned CLKDROP_IDX = 10,
   parameter int unsigned CMD_W       = 7,
   parameter int unsigned SUP_W       = 11,
   parameter int unsigned SRC_W       = 11,
   parameter int unsigned TYPE_W      = 4,
   parameter int unsigned ADDR_W      = 38
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_ERR-1:0] strobe,
   input  logic [CMD_W-1:0]   pkt_cmd,
   input  logic [SUP_W-1:0]   pkt_suppl,
   input  logic [SRC_W-1:0]   pkt_src,
   input  logic [ADDR_W-1:0]  pkt_addr,
   input  logic               pkt_is_vector,
   input  logic [WORD_W-1:0]  pkt_flit2,
   input  logic [WORD_W-1:0]  pkt_flit3,
   input  logic               wr_hdr1,
   input  logic               wr_hdr2,
   input  logic               wr_data,
   input  logic [WORD_W-1:0]  wdata,
   output logic               valid_q,
   output logic               ovr_q,
   output logic [TYPE_W-1:0]  type_q,
   output logic [CMD_W-1:0]   cmd_q,
   output logic [SUP_W-1:0]   sup_q,
   output logic [SRC_W-1:0]   src_q,
   output logic [ADDR_W-1:0]  addr_q,
   output logic [WORD_W-1:0]  data_q,
   output logic               eligible_hit
);
   logic [NUM_ERR-1:0] elig;
   logic [TYPE_W-1:0]  first_idx;
   logic               take;
   logic               unused_wdata;

   assign unused_wdata = ^wdata;

   always_comb begin
      elig              = strobe;
      elig[CLKDROP_IDX] = 1'b0;
   end

   // lowest-indexed eligible strobe names the type
   always_comb begin
      first_idx = '0;
      for (int i = NUM_ERR - 1; i >= 0; i--) begin
         if (elig[i]) first_idx = TYPE_W'(i);
      end
   end

   assign eligible_hit = |elig;
   assign take         = eligible_hit & ~valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         ovr_q   <= 1'b0;
         type_q  <= '0;
         cmd_q   <= '0;
         sup_q   <= '0;
         src_q   <= '0;
      end else if (take) begin
         valid_q <= 1'b1;
         ovr_q   <= 1'b0;
         type_q  <= first_idx;
         cmd_q   <= pkt_cmd;
         sup_q   <= pkt_suppl;
         src_q   <= pkt_src;
      end else if (eligible_hit) begin
         ovr_q   <= 1'b1;
      end else if (wr_hdr1) begin
         valid_q <= wdata[H1_VLD_BIT];
         ovr_q   <= wdata[H1_OVR_BIT];
         type_q  <= wdata[H1_TYPE_LSB +: TYPE_W];
         cmd_q   <= wdata[H1_CMD_LSB +: CMD_W];
         sup_q   <= wdata[H1_SUP_LSB +: SUP_W];
         src_q   <= wdata[H1_SRC_LSB +: SRC_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else begin
         if (take)         addr_q <= pkt_addr;
         else if (wr_hdr2) addr_q <= wdata[ADDR_W-1:0];
         if (take)         data_q <= pkt_is_vector ? pkt_flit3 : pkt_flit2;
         else if (wr_data) data_q <= wdata;
      end
   end
endmodule

// File: rtl/err_regif.sv
module err_regif
   import err_log_pkg::*;
#(
   parameter int unsigned NUM_ERR = 11,
   parameter int unsigned CMD_W   = 7,
   parameter int unsigned SUP_W   = 11,
   parameter int unsigned SRC_W   = 11,
   parameter int unsigned TYPE_W  = 4,
   parameter int unsigned ADDR_W  = 38
) (
   input  logic               reg_wr,
   input  logic [RADDR_W-1:0] reg_addr,
   input  logic [WORD_W-1:0]  reg_wdata,
   input  logic [NUM_ERR-1:0] status,
   input  logic               valid_q,
   input  logic               ovr_q,
   input  logic [TYPE_W-1:0]  type_q,
   input  logic [CMD_W-1:0]   cmd_q,
   input  logic [SUP_W-1:0]   sup_q,
   input  logic [SRC_W-1:0]   src_q,
   input  logic [ADDR_W-1:0]  addr_q,
   input  logic [WORD_W-1:0]  data_q,
   output logic [NUM_ERR-1:0] sw_set,
   output logic [NUM_ERR-1:0] sw_clr,
   output logic               wr_hdr1,
   output logic               wr_hdr2,
   output logic               wr_data,
   output logic [WORD_W-1:0]  reg_rdata
);
   reg_sel_e sel;
   logic     unused_wdata;

   assign sel          = reg_sel_e'(reg_addr);
   assign unused_wdata = ^reg_wdata;

   assign sw_set  = (reg_wr && sel == RSEL_STATUS) ? reg_wdata[NUM_ERR-1:0] : '0;
   assign sw_clr  = (reg_wr && sel == RSEL_CLEAR)  ? reg_wdata[NUM_ERR-1:0] : '0;
   assign wr_hdr1 = reg_wr && sel == RSEL_HDR1;
   assign wr_hdr2 = reg_wr && sel == RSEL_HDR2;
   assign wr_data = reg_wr && sel == RSEL_DATA;

   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         RSEL_STATUS: reg_rdata[NUM_ERR-1:0] = status;
         RSEL_HDR1: begin
            reg_rdata[H1_CMD_LSB +: CMD_W]   = cmd_q;
            reg_rdata[H1_SUP_LSB +: SUP_W]   = sup_q;
            reg_rdata[H1_SRC_LSB +: SRC_W]   = src_q;
            reg_rdata[H1_TYPE_LSB +: TYPE_W] = type_q;
            reg_rdata[H1_OVR_BIT]            = ovr_q;
            reg_rdata[H1_VLD_BIT]            = valid_q;
         end
         RSEL_HDR2:   reg_rdata[ADDR_W-1:0] = addr_q;
         RSEL_DATA:   reg_rdata = data_q;
         default:     reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/err_log_unit.sv
module err_log_unit
   import err_log_pkg::*;
#(
   parameter int unsigned NUM_ERR     = 11,
   parameter int unsigned CLKDROP_IDX = 10,
   parameter int unsigned CMD_W       = 7,
   parameter int unsigned SUP_W       = 11,
   parameter int unsigned SRC_W       = 11,
   parameter int unsigned TYPE_W      = 4,
   parameter int unsigned ADDR_W      = 38
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_ERR-1:0] err_strobe,
   input  logic [CMD_W-1:0]   pkt_cmd,
   input  logic [SUP_W-1:0]   pkt_suppl,
   input  logic [SRC_W-1:0]   pkt_src,
   input  logic [ADDR_W-1:0]  pkt_addr,
   input  logic               pkt_is_vector,
   input  logic [WORD_W-1:0]  pkt_flit2,
   input  logic [WORD_W-1:0]  pkt_flit3,
   input  logic               reg_wr,
   input  logic [RADDR_W-1:0] reg_addr,
   input  logic [WORD_W-1:0]  reg_wdata,
   output logic [WORD_W-1:0]  reg_rdata,
   output logic               irq
);
   localparam int unsigned TYPE_CODES = 1 << TYPE_W;

   if (NUM_ERR > TYPE_CODES || NUM_ERR >= WORD_W || CLKDROP_IDX >= NUM_ERR ||
       CMD_W > H1_SUP_LSB - H1_CMD_LSB || SUP_W > H1_SRC_LSB - H1_SUP_LSB ||
       SRC_W > H1_TYPE_LSB - H1_SRC_LSB || TYPE_W > H1_OVR_BIT - H1_TYPE_LSB ||
       ADDR_W > WORD_W) begin : g_bad_cfg
      $error("err_log_unit: parameter set does not fit the register layout");
   end

   logic [NUM_ERR-1:0] status_vec, sw_set, sw_clr;
   logic               cap_valid, cap_ovr, wr_hdr1, wr_hdr2, wr_data, elig_hit;
   logic [TYPE_W-1:0]  cap_type;
   logic [CMD_W-1:0]   cap_cmd;
   logic [SUP_W-1:0]   cap_sup;
   logic [SRC_W-1:0]   cap_src;
   logic [ADDR_W-1:0]  cap_addr;
   logic [WORD_W-1:0]  cap_data;

   err_status_vec #(.NUM_ERR(NUM_ERR)) u_status (
      .clk     (clk),
      .hw_set  (err_strobe),
      .sw_set  (sw_set),
      .sw_clr  (sw_clr),
      .status  (status_vec),
      .any_set (irq)
   );

   err_capture #(
      .NUM_ERR(NUM_ERR), .CLKDROP_IDX(CLKDROP_IDX), .CMD_W(CMD_W),
      .SUP_W(SUP_W), .SRC_W(SRC_W), .TYPE_W(TYPE_W), .ADDR_W(ADDR_W)
   ) u_capture (
      .clk           (clk),
      .rst_n         (rst_n),
      .strobe        (err_strobe),
      .pkt_cmd       (pkt_cmd),
      .pkt_suppl     (pkt_suppl),
      .pkt_src       (pkt_src),
      .pkt_addr      (pkt_addr),
      .pkt_is_vector (pkt_is_vector),
      .pkt_flit2     (pkt_flit2),
      .pkt_flit3     (pkt_flit3),
      .wr_hdr1       (wr_hdr1),
      .wr_hdr2       (wr_hdr2),
      .wr_data       (wr_data),
      .wdata         (reg_wdata),
      .valid_q       (cap_valid),
      .ovr_q         (cap_ovr),
      .type_q        (cap_type),
      .cmd_q         (cap_cmd),
      .sup_q         (cap_sup),
      .src_q         (cap_src),
      .addr_q        (cap_addr),
      .data_q        (cap_data),
      .eligible_hit  (elig_hit)
   );

   err_regif #(
      .NUM_ERR(NUM_ERR), .CMD_W(CMD_W), .SUP_W(SUP_W), .SRC_W(SRC_W),
      .TYPE_W(TYPE_W), .ADDR_W(ADDR_W)
   ) u_regif (
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .status    (status_vec),
      .valid_q   (cap_valid),
      .ovr_q     (cap_ovr),
      .type_q    (cap_type),
      .cmd_q     (cap_cmd),
      .sup_q     (cap_sup),
      .src_q     (cap_src),
      .addr_q    (cap_addr),
      .data_q    (cap_data),
      .sw_set    (sw_set),
      .sw_clr    (sw_clr),
      .wr_hdr1   (wr_hdr1),
      .wr_hdr2   (wr_hdr2),
      .wr_data   (wr_data),
      .reg_rdata (reg_rdata)
   );
endmodule

// File: rtl/err_log_chk.sv
module err_log_chk #(
   parameter int unsigned NUM_ERR     = 11,
   parameter int unsigned CLKDROP_IDX = 10,
   parameter int unsigned TYPE_W      = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_ERR-1:0] err_strobe,
   input logic               reg_wr,
   input logic [2:0]         reg_addr,
   input logic [63:0]        reg_rdata,
   input logic               irq,
   input logic [NUM_ERR-1:0] status,
   input logic               valid,
   input logic               ovr,
   input logic [TYPE_W-1:0]  etype
);
   logic [NUM_ERR-1:0] elig;
   logic [NUM_ERR-1:0] drop_only;

   always_comb begin
      elig              = err_strobe;
      elig[CLKDROP_IDX] = 1'b0;
      drop_only         = '0;
      drop_only[CLKDROP_IDX] = 1'b1;
   end

   AST_STROBE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (err_strobe != '0) |=> ((status & $past(err_strobe)) == $past(err_strobe))); // R5

   AST_IRQ_MATCHES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 3'd0) |-> (irq == (reg_rdata != 64'd0))); // R3

   AST_STATUS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (err_strobe == '0 && !reg_wr) |=> $stable(status)); // R2

   AST_FIRST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (!valid && elig != '0) |=> (valid && !ovr)); // R6

   AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && elig != '0) |=> (valid && ovr && $stable(etype))); // R7

   AST_CLKDROP_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (err_strobe == drop_only && !(reg_wr && reg_addr == 3'd2))
      |=> ($stable(valid) && $stable(ovr) && $stable(etype))); // R8

   AST_STATUS_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 3'd0) |-> (reg_rdata[63:NUM_ERR] == '0)); // R12
endmodule

bind err_log_unit err_log_chk #(
   .NUM_ERR(NUM_ERR), .CLKDROP_IDX(CLKDROP_IDX), .TYPE_W(TYPE_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .err_strobe (err_strobe),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .reg_rdata  (reg_rdata),
   .irq        (irq),
   .status     (status_vec),
   .valid      (cap_valid),
   .ovr        (cap_ovr),
   .etype      (cap_type)
);

// File: tb/err_log_unit_tb.sv
module err_log_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] err_strobe = '0;
   logic [6:0]  pkt_cmd = '0;
   logic [10:0] pkt_suppl = '0;
   logic [10:0] pkt_src = '0;
   logic [37:0] pkt_addr = '0;
   logic        pkt_is_vector = 1'b0;
   logic [63:0] pkt_flit2 = '0;
   logic [63:0] pkt_flit3 = '0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;

   // reference model state
   logic [10:0] m_stat = '0;
   bit          m_vld, m_ovr;
   logic [3:0]  m_type;
   logic [6:0]  m_cmd;
   logic [10:0] m_sup, m_src;
   logic [37:0] m_addr;
   logic [63:0] m_data;

   always #10 clk = ~clk;

   err_log_unit u_dut (
      .clk(clk), .rst_n(rst_n), .err_strobe(err_strobe), .pkt_cmd(pkt_cmd),
      .pkt_suppl(pkt_suppl), .pkt_src(pkt_src), .pkt_addr(pkt_addr),
      .pkt_is_vector(pkt_is_vector), .pkt_flit2(pkt_flit2), .pkt_flit3(pkt_flit3),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   function automatic logic [63:0] exp_rd(input logic [2:0] a);
      logic [63:0] v = '0;
      case (a)
         3'd0: v[10:0] = m_stat;
         3'd2: begin
            v[6:0] = m_cmd; v[18:8] = m_sup; v[30:20] = m_src;
            v[35:32] = m_type; v[40] = m_ovr; v[44] = m_vld;
         end
         3'd3: v[37:0] = m_addr;
         3'd4: v = m_data;
         default: v = '0;
      endcase
      return v;
   endfunction

   task automatic model_update();
      logic [10:0] el = err_strobe & 11'h3FF;
      logic [10:0] nstat = m_stat;
      if (reg_wr && reg_addr == 3'd1) nstat = nstat & ~reg_wdata[10:0];
      if (reg_wr && reg_addr == 3'd0) nstat = nstat | reg_wdata[10:0];
      nstat = nstat | err_strobe;
      m_stat = nstat;
      if (!rst_n) begin
         m_vld = 0; m_ovr = 0; m_type = '0; m_cmd = '0; m_sup = '0; m_src = '0;
         m_addr = '0; m_data = '0;
      end else if (el != 0 && !m_vld) begin
         m_vld = 1; m_ovr = 0;
         for (int i = 10; i >= 0; i--) if (el[i]) m_type = 4'(i);
         m_cmd = pkt_cmd; m_sup = pkt_suppl; m_src = pkt_src; m_addr = pkt_addr;
         m_data = pkt_is_vector ? pkt_flit3 : pkt_flit2;
      end else begin
         if (el != 0) m_ovr = 1;
         else if (reg_wr && reg_addr == 3'd2) begin
            m_cmd = reg_wdata[6:0]; m_sup = reg_wdata[18:8]; m_src = reg_wdata[30:20];
            m_type = reg_wdata[35:32]; m_ovr = reg_wdata[40]; m_vld = reg_wdata[44];
         end
         if (reg_wr && reg_addr == 3'd3) m_addr = reg_wdata[37:0];
         if (reg_wr && reg_addr == 3'd4) m_data = reg_wdata;
      end
   endtask

   task automatic expect64(input logic [63:0] act, input logic [63:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one clock: model steps at the edge, outputs compared at the falling edge
   task automatic cyc(input string tag);
      @(posedge clk);
      model_update();
      @(negedge clk);
      expect64({63'd0, irq}, {63'd0, m_stat != 0}, {tag, " irq"});
      expect64(reg_rdata, exp_rd(reg_addr), {tag, " rdata"});
   endtask

   task automatic wr(input logic [2:0] a, input logic [63:0] d, input string tag);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      cyc(tag);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, input string tag);
      reg_addr = a;
      cyc(tag);
   endtask

   task automatic pkt(input logic [10:0] s, input logic [6:0] c, input logic [10:0] sp,
                      input logic [10:0] sr, input logic [37:0] ad, input bit vec,
                      input logic [63:0] f2, input logic [63:0] f3);
      err_strobe = s; pkt_cmd = c; pkt_suppl = sp; pkt_src = sr; pkt_addr = ad;
      pkt_is_vector = vec; pkt_flit2 = f2; pkt_flit3 = f3;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      @(negedge clk);
      cyc("R12 reset");
      rst_n = 1'b1;
      // R12: reset state and empty addresses
      for (int a = 0; a < 8; a++) rd(3'(a), "R12");
      // R1 R6 R9 R10: first error, reply long, normal packet
      pkt(11'h020, 7'h5A, 11'h3C1, 11'h2A5, 38'h2A_BCDE_F012, 1'b0,
          64'h1111_2222_3333_4444, 64'hDEAD_BEEF_0000_0001);
      reg_addr = 3'd2;
      cyc("R6 capture");
      err_strobe = '0;
      expect64({60'd0, reg_rdata[35:32]}, 64'd5, "R6 type");
      expect64({63'd0, reg_rdata[44]}, 64'd1, "R9 valid bit");
      rd(3'd0, "R1 status");
      rd(3'd3, "R9 hdr2");
      rd(3'd4, "R10 data normal");
      // R7: second error while valid
      pkt(11'h004, 7'h11, 11'h001, 11'h002, 38'h1, 1'b1, 64'h5, 64'h6);
      reg_addr = 3'd2;
      cyc("R7 overrun");
      err_strobe = '0;
      rd(3'd3, "R7 addr kept");
      rd(3'd4, "R7 data kept");
      // R8: clock drop while valid
      pkt(11'h400, 7'h22, 11'h0, 11'h0, 38'h77, 1'b0, 64'h9, 64'h9);
      reg_addr = 3'd2;
      cyc("R8 drop valid");
      err_strobe = '0;
      rd(3'd0, "R1 drop bit");
      // R5: clear bits 2 and 5 only
      wr(3'd1, 64'hFFFF_FFFF_FFFF_F024, "R5 clear");
      rd(3'd0, "R5 after clear");
      rd(3'd1, "R12 clear reads 0");
      // R5: set wins over clear of same bit
      err_strobe = 11'h001;
      wr(3'd1, 64'h401, "R5 set wins");
      err_strobe = '0;
      rd(3'd0, "R5 set wins read");
      // R11: clear valid by writing 0
      wr(3'd2, 64'd0, "R11 clear valid");
      rd(3'd2, "R11 hdr1");
      // R8: clock drop with valid 0 does not capture
      pkt(11'h400, 7'h33, 11'h1, 11'h1, 38'h99, 1'b0, 64'h7, 64'h8);
      cyc("R8 drop no capture");
      err_strobe = '0;
      rd(3'd2, "R8 hdr1");
      // R6 R10: two strobes, vector packet, lowest index wins
      pkt(11'h488, 7'h7F, 11'h7FF, 11'h400, 38'h3F_FFFF_FFFF, 1'b1,
          64'hAAAA_0000_0000_0002, 64'hBBBB_CCCC_DDDD_EEEE);
      cyc("R6 multi");
      err_strobe = '0;
      rd(3'd2, "R6 type 3");
      expect64({60'd0, reg_rdata[35:32]}, 64'd3, "R6 lowest index");
      rd(3'd4, "R10 data vector");
      // R11: header write loses to an error in the same cycle
      err_strobe = 11'h002;
      wr(3'd2, 64'h0000_1000_0000_0000, "R11 hw wins");
      err_strobe = '0;
      rd(3'd2, "R11 after collision");
      // R11: writes to hdr2 and data, R12 reserved bits
      wr(3'd2, 64'hFFFF_FFFF_FFFF_FFFF, "R12 hdr1 rsvd");
      rd(3'd2, "R12 hdr1 read");
      wr(3'd3, 64'hFFFF_FFFF_FFFF_FFFF, "R12 hdr2 rsvd");
      rd(3'd3, "R12 hdr2 read");
      wr(3'd4, 64'h0123_4567_89AB_CDEF, "R11 data write");
      rd(3'd4, "R11 data read");
      // R3 R4: clear all, irq low, then software set
      wr(3'd1, 64'h7FF, "R3 clear all");
      rd(3'd0, "R3 irq low");
      expect64({63'd0, irq}, 64'd0, "R3 irq zero");
      wr(3'd0, 64'hFFFF_0000_0000_0081, "R4 sw set");
      wr(3'd0, 64'h0000_0000_0000_0100, "R4 sw set or");
      rd(3'd0, "R4 read");
      expect64(reg_rdata, 64'h181, "R4 value");
      // R2: repeated reads are non-destructive
      for (int k = 0; k < 3; k++) rd(3'd0, "R2 read hold");
      // R2 R12: reset keeps status, clears capture
      rst_n = 1'b0;
      cyc("R2 in reset");
      cyc("R2 in reset");
      rst_n = 1'b1;
      rd(3'd0, "R2 survives reset");
      expect64(reg_rdata, 64'h181, "R2 status kept");
      rd(3'd2, "R12 capture reset");
      rd(3'd4, "R12 data reset");
      summary();
      $finish;
   end
endmodule